// File: doc/BRIEF.md
# Wavetable Playback Address Engine

This block generates sample addresses for one playback voice of a wavetable sound engine. Software programs a loop base address, a starting sample offset, an end offset (the buffer length in samples minus one), a rate increment and a sample-format code through a small write window. It then issues a start pulse. On every output-rate tick (48 kHz in the system), a phase accumulator with a 12-bit fraction advances the current sample offset by the rate. The offset restarts at zero once it would pass the end offset.

Each advance presents a byte address to the fetch path. The address is the base plus the offset scaled by the sample size: 1, 2 or 4 bytes for 8-bit mono, 8-bit stereo or 16-bit mono, and 16-bit stereo. The block also shows which half of the buffer the offset is in. It raises a one-cycle event strobe when the offset wraps and when it enters the upper half. Software uses that strobe, the half flag and the readable offset to refill the buffer in a double-buffered way. Memory fetch, interpolation, volume and mixing are outside this block.

Top module: `wt_addr_engine`

## Requirements
- R1: After a clock edge with `rst_n` low, `running`, `cur_ofs`, `fetch_valid`, `irq` and `fetch_addr` are all zero and every configuration register is zero.
- R2: A write with `cfg_we` high takes effect at the next edge. The `cfg_sel` codes are: 0 for the loop base (bits 29:0 are kept, bits 31:30 are ignored), 1 for the current offset (low `OFS_W` bits), 2 for the end offset (low `OFS_W` bits), 3 for the rate (bits 15:0) and 4 for the format (bits 3:0).
- R3: A `start` pulse sets `running` at the next edge and clears the fraction accumulator. A `stop` pulse clears `running` at the next edge. When both pulses arrive in the same cycle, `stop` wins.
- R4: The offset advances on a `tick` cycle only when `running` is 1 and format bit 0 (enable) is 1. On an advance, the fraction becomes (fraction + rate[11:0]) mod 4096, and the offset grows by rate[15:12] plus the carry out of that sum. A rate of 0x1000 therefore moves one sample per tick. Without an advance, the offset and the fraction hold.
- R5: When the advanced value would exceed the end offset, the offset becomes 0 instead. The fraction is still updated.
- R6: `half_flag` is 1 exactly when `cur_ofs` is at least (end offset + 1) / 2, rounded down.
- R7: `irq` is high for the one cycle that follows an advance that either wraps or moves `half_flag` from 0 to 1. It is low at all other times.
- R8: `fetch_valid` is high for the one cycle that follows each advance. `fetch_addr` always equals base + (`cur_ofs` << s) modulo 2^32. The shift s is format bit 3 (16-bit) plus format bit 2 (stereo). Format bit 1 (signed) has no effect on the address.
- R9: A write to the current offset in the same cycle as an advancing tick wins over the advance. The `irq` and `fetch_valid` pulses of that advance still occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| tick | input | 1 | Output-sample-rate tick |
| running | output | 1 | Voice is running |
| cur_ofs | output | OFS_W | Current sample offset |
| half_flag | output | 1 | Offset lies in the upper half of the buffer |
| fetch_valid | output | 1 | A new sample address is presented |
| fetch_addr | output | ADDR_W | Byte address of the current sample |
| irq | output | 1 | Wrap or half-crossing event strobe |

## Verification
The hidden state that matters is the fraction accumulator. A wrong fraction does not show at once. It shows as a `cur_ofs` that is one sample early or late on the first tick whose carry differs, which may be several ticks after the fault. The bench therefore runs long tick trains with fractional rates and compares every cycle.

A wrong wrap or half decision shows within one cycle of the advance that causes it. It appears as a missing or extra `irq` pulse and as a `cur_ofs` that is not zero. A wrong format decode shows at once on `fetch_addr` as a scale error.

// File: rtl/wt_pkg.sv
// Shared definitions for the wavetable address engine.
// Assumes format bits: 0 enable, 1 signed, 2 stereo, 3 sixteen-bit.
package wt_pkg;
    localparam int FMT_W      = 4;
    localparam int FMT_ENA    = 0;
    localparam int FMT_SIGNED = 1;
    localparam int FMT_STEREO = 2;
    localparam int FMT_WIDE   = 3;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_CUR  = 3'd1,
        SEL_END  = 3'd2,
        SEL_RATE = 3'd3,
        SEL_FMT  = 3'd4
    } cfg_sel_e;

    // Byte-size shift for a sample of the given width/channel bits.
    function automatic logic [1:0] size_shift(input logic wide, input logic stereo);
        return {1'b0, wide} + {1'b0, stereo};
    endfunction
endpackage

// File: rtl/wt_regs.sv
// Configuration window: holds base, end offset, rate and format.
// A write to the current offset is passed on as a one-cycle request
// because the offset itself lives in the phase accumulator.
// Assumes a single-cycle write strobe; unknown selects are dropped.
module wt_regs #(
    parameter int BASE_W = 30,
    parameter int OFS_W  = 16,
    parameter int RATE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [2:0]              sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic [BASE_W-1:0]       base,
    output logic [OFS_W-1:0]        end_ofs,
    output logic [RATE_W-1:0]       rate,
    output logic [wt_pkg::FMT_W-1:0] fmt,
    output logic                    cur_wr,
    output logic [OFS_W-1:0]        cur_wdata
);
    import wt_pkg::*;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Register the configuration fields on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            end_ofs <= '0;
            rate    <= '0;
            fmt     <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_BASE: base    <= wdata[BASE_W-1:0];
                SEL_END:  end_ofs <= wdata[OFS_W-1:0];
                SEL_RATE: rate    <= wdata[RATE_W-1:0];
                SEL_FMT:  fmt     <= wdata[FMT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Forward an offset write to the accumulator.
    always_comb begin
        cur_wr    = we && (cfg_sel_e'(sel) == SEL_CUR);
        cur_wdata = wdata[OFS_W-1:0];
    end
endmodule

// File: rtl/wt_phase.sv
// Phase accumulator for one voice. It keeps the integer sample offset
// and a fractional part. On an enabled tick it adds the rate and
// restarts at zero past the end offset. It reports the buffer half and
// a registered event on a wrap or on entry to the upper half.
// Assumes RATE_W > FRAC_W.
module wt_phase #(
    parameter int OFS_W  = 16,
    parameter int RATE_W = 16,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              tick,
    input  logic              fmt_ena,
    input  logic [RATE_W-1:0] rate,
    input  logic [OFS_W-1:0]  end_ofs,
    input  logic              cur_wr,
    input  logic [OFS_W-1:0]  cur_wdata,
    output logic              running,
    output logic [OFS_W-1:0]  cur,
    output logic              half,
    output logic              adv_q,
    output logic              evt_q
);
    localparam int INT_W = RATE_W - FRAC_W;

    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   frac_sum;
    logic [INT_W:0]    step;
    logic [OFS_W:0]    ofs_sum;
    logic [OFS_W:0]    half_pt;
    logic              wrap;
    logic              half_nx;
    logic [OFS_W-1:0]  cur_nx;
    logic              adv;

    // Step size, candidate offset, wrap and half decisions.
    always_comb begin
        adv      = tick && running && fmt_ena;
        frac_sum = {1'b0, frac} + {1'b0, rate[FRAC_W-1:0]};
        step     = {1'b0, rate[RATE_W-1:FRAC_W]} + (INT_W+1)'(frac_sum[FRAC_W]);
        ofs_sum  = {1'b0, cur} + (OFS_W+1)'(step);
        wrap     = ofs_sum > {1'b0, end_ofs};
        cur_nx   = wrap ? '0 : ofs_sum[OFS_W-1:0];
        half_pt  = ({1'b0, end_ofs} + (OFS_W+1)'(1)) >> 1;
        half     = {1'b0, cur} >= half_pt;
        half_nx  = {1'b0, cur_nx} >= half_pt;
    end

    // Run state: stop has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)      running <= 1'b0;
        else if (stop)   running <= 1'b0;
        else if (start)  running <= 1'b1;
    end

    // Fraction: cleared on start, otherwise advanced.
    always_ff @(posedge clk) begin
        if (!rst_n)      frac <= '0;
        else if (start)  frac <= '0;
        else if (adv)    frac <= frac_sum[FRAC_W-1:0];
    end

    // Integer offset: a software write wins over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (cur_wr) cur <= cur_wdata;
        else if (adv)    cur <= cur_nx;
    end

    // Fetch strobe and wrap/half event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            adv_q <= adv;
            evt_q <= adv && (wrap || (!half && half_nx));
        end
    end
endmodule

// File: rtl/wt_addr_gen.sv
// Byte address of the current sample: base plus the offset scaled by
// the sample size taken from the format bits. Purely combinational.
// Assumes ADDR_W covers BASE_W and the offset shifted by two.
module wt_addr_gen #(
    parameter int BASE_W = 30,
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [BASE_W-1:0] base,
    input  logic [OFS_W-1:0]  cur,
    input  logic              wide,
    input  logic              stereo,
    output logic [ADDR_W-1:0] addr
);
    import wt_pkg::*;

    logic [1:0] shamt;

    // Scale the offset and add the base.
    always_comb begin
        shamt = size_shift(wide, stereo);
        addr  = ADDR_W'(base) + (ADDR_W'(cur) << shamt);
    end
endmodule

// File: rtl/wt_addr_engine.sv
// Top level of one voice's address engine: configuration window,
// phase accumulator and address generator.
// Assumes start/stop/tick are single-cycle pulses in the clk domain.
module wt_addr_engine #(
    parameter int BASE_W = 30,
    parameter int OFS_W  = 16,
    parameter int RATE_W = 16,
    parameter int FRAC_W = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              start,
    input  logic              stop,
    input  logic              tick,
    output logic              running,
    output logic [OFS_W-1:0]  cur_ofs,
    output logic              half_flag,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              irq
);
    import wt_pkg::*;

    logic [BASE_W-1:0] base;
    logic [OFS_W-1:0]  end_ofs;
    logic [RATE_W-1:0] rate;
    logic [FMT_W-1:0]  fmt;
    logic              cur_wr;
    logic [OFS_W-1:0]  cur_wdata;
    logic              unused_signed;

    assign unused_signed = fmt[FMT_SIGNED];

    wt_regs #(.BASE_W(BASE_W), .OFS_W(OFS_W), .RATE_W(RATE_W), .DATA_W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .base(base), .end_ofs(end_ofs), .rate(rate), .fmt(fmt),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata)
    );

    wt_phase #(.OFS_W(OFS_W), .RATE_W(RATE_W), .FRAC_W(FRAC_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
        .fmt_ena(fmt[FMT_ENA]), .rate(rate), .end_ofs(end_ofs),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata),
        .running(running), .cur(cur_ofs), .half(half_flag),
        .adv_q(fetch_valid), .evt_q(irq)
    );

    wt_addr_gen #(.BASE_W(BASE_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_addr (
        .base(base), .cur(cur_ofs), .wide(fmt[FMT_WIDE]), .stereo(fmt[FMT_STEREO]),
        .addr(fetch_addr)
    );
endmodule

// File: rtl/wt_addr_engine_chk.sv
// Protocol checker for wt_addr_engine, bound to every instance.
module wt_addr_engine_chk #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             start,
    input logic             stop,
    input logic             tick,
    input logic             running,
    input logic [OFS_W-1:0] cur_ofs,
    input logic             fetch_valid,
    input logic             irq
);
    p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);

    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> running);

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cfg_we) |=> $stable(cur_ofs));

    p_evt_on_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fetch_valid);

    p_fetch_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> $past(tick));
endmodule

bind wt_addr_engine wt_addr_engine_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .start(start), .stop(stop),
    .tick(tick), .running(running), .cur_ofs(cur_ofs),
    .fetch_valid(fetch_valid), .irq(irq)
);

// File: tb/tb_wt_addr_engine.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the DUT every cycle.
module tb_wt_addr_engine;
    localparam int OFS_W = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        start = 0, stop = 0, tick = 0;
    logic        running, half_flag, fetch_valid, irq;
    logic [OFS_W-1:0] cur_ofs;
    logic [31:0] fetch_addr;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 0;

    // Model state.
    longint m_base, m_cur, m_end, m_rate, m_fmt, m_frac;
    bit m_run, m_fv, m_irq;

    always #2 clk = ~clk;

    wt_addr_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .stop(stop), .tick(tick),
        .running(running), .cur_ofs(cur_ofs), .half_flag(half_flag),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .irq(irq)
    );

    function automatic bit m_half(longint c, longint e);
        return c >= ((e + 1) >> 1);
    endfunction

    function automatic longint m_addr();
        longint sh;
        sh = ((m_fmt >> 3) & 1) + ((m_fmt >> 2) & 1);
        return (m_base + (m_cur << sh)) & 64'hFFFF_FFFF;
    endfunction

    // Reference model update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_cur = 0; m_end = 0; m_rate = 0; m_fmt = 0;
            m_frac = 0; m_run = 0; m_fv = 0; m_irq = 0;
        end else begin
            bit adv, wrap;
            longint fs, nc, nf;
            adv  = tick && m_run && m_fmt[0];
            fs   = m_frac + (m_rate & 'hFFF);
            nf   = fs & 'hFFF;
            nc   = m_cur + (m_rate >> 12) + (fs >> 12);
            wrap = nc > m_end;
            if (wrap) nc = 0;
            m_fv  = adv;
            m_irq = adv && (wrap || (!m_half(m_cur, m_end) && m_half(nc, m_end)));
            if (start) m_frac = 0; else if (adv) m_frac = nf;
            if (cfg_we && cfg_sel == 1) m_cur = cfg_wdata & 'hFFFF;
            else if (adv) m_cur = nc;
            if (stop) m_run = 0; else if (start) m_run = 1;
            if (cfg_we) begin
                case (cfg_sel)
                    0: m_base = cfg_wdata & 32'h3FFF_FFFF;
                    2: m_end  = cfg_wdata & 'hFFFF;
                    3: m_rate = cfg_wdata & 'hFFFF;
                    4: m_fmt  = cfg_wdata & 'hF;
                    default: ;
                endcase
            end
            cmp_en = 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R3 running", running, m_run);
            chk("R4 cur_ofs", cur_ofs, m_cur);
            chk("R6 half_flag", half_flag, m_half(m_cur, m_end));
            chk("R7 irq", irq, m_irq);
            chk("R8 fetch_valid", fetch_valid, m_fv);
            chk("R8 fetch_addr", fetch_addr, m_addr());
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
        cyc();
        cfg_we = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc(); tick = 0;
            for (int g = 0; g < gap; g++) cyc();
        end
    endtask

    task automatic pulse_start();
        start = 1; cyc(); start = 0;
    endtask

    task automatic pulse_stop();
        stop = 1; cyc(); stop = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [OFS_W-1:0] held;
        repeat (3) cyc();
        @(negedge clk);
        chk("R1 reset running", running, 0);
        chk("R1 reset cur_ofs", cur_ofs, 0);
        chk("R1 reset fetch_addr", fetch_addr, 0);
        chk("R1 reset irq", irq, 0);
        cyc();
        rst_n = 1;
        cyc();

        // R2: base bits 31:30 ignored
        wr(0, 32'hC000_1000);
        @(negedge clk);
        chk("R2 base mask", fetch_addr, 32'h0000_1000);
        cyc();
        wr(2, 15); wr(3, 32'h1000); wr(4, 1); wr(1, 0);
        pulse_start();
        ticks(20, 1);

        // R8: 16-bit stereo scaling, half rate; signed bit set
        wr(4, 32'hF);
        wr(3, 32'h0800);
        ticks(24, 0);
        // R8: 8-bit stereo, fractional 1.5 rate
        wr(4, 32'h5);
        wr(3, 32'h1800);
        ticks(25, 2);

        // R5: large step wraps to zero
        wr(3, 32'h5000);
        wr(1, 12);
        ticks(1, 0);
        @(negedge clk);
        chk("R5 wrap to zero", cur_ofs, 0);
        cyc();
        ticks(12, 1);

        // R4: enable bit clear -> no advance
        wr(4, 32'hE);
        held = cur_ofs;
        ticks(5, 0);
        @(negedge clk);
        chk("R4 enable clear holds", cur_ofs, held);
        cyc();
        wr(4, 32'h9);

        // R3: stop blocks advance, stop wins with start
        pulse_stop();
        held = cur_ofs;
        ticks(4, 0);
        @(negedge clk);
        chk("R4 stopped holds", cur_ofs, held);
        cyc();
        start = 1; stop = 1; cyc(); start = 0; stop = 0;
        @(negedge clk);
        chk("R3 stop wins", running, 0);
        cyc();
        pulse_start();

        // R9: offset write wins over a same-cycle tick
        wr(3, 32'h1000);
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 7; tick = 1;
        cyc();
        cfg_we = 0; tick = 0;
        @(negedge clk);
        chk("R9 write wins", cur_ofs, 7);
        chk("R9 fetch pulse kept", fetch_valid, 1);
        cyc();

        // Wider buffer, odd length, fractional rate
        wr(2, 100); wr(1, 0); wr(3, 32'h0D55);
        pulse_start();
        ticks(150, 0);
        wr(2, 0);
        ticks(6, 1);
        repeat (4) cyc();

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule